// File: doc/BRIEF.md
# Multi-Channel Serial Result Shifter

This block is the output stage of an eight-channel, 18-bit converter. When the converter's busy signal falls, it copies a fresh set of eight results into its output registers. An external host then pulls the results out through an active-low chip select and a serial clock. The block can use two data lanes or one, and it drives a flag that marks when channel 1 is on the wire. All logic runs on one system clock. The chip select, serial clock and busy inputs are taken as already synchronous to it, and the block detects their edges by comparing each input with its value on the previous cycle. Tri-state pins are modelled as data outputs, each paired with an output enable.

In dual-lane mode, lane A carries channels 1 to 4 and lane B carries channels 5 to 8, both at once. In single-lane mode, lane B carries channels 1 to 8 in order and lane A stays disabled. Each result goes out MSB first. The MSB appears as soon as the chip select falls. Each following bit appears on a serial-clock rising edge, but only on a rising edge that comes after a falling edge. A host that idles the clock high therefore samples each bit on the falling edge.

The sequencer has three states. IDLE holds while the chip select is high. IDLE goes to SHIFT when the chip select is seen low. SHIFT goes to DRAIN on the rising edge that completes the last bit of the last channel for the mode. Both SHIFT and DRAIN go back to IDLE when the chip select goes high. In DRAIN the enables stay on and the data lanes carry zeros.

Top module: `ser_out_shifter`

## Requirements
- R1: The output registers take conv_data on a cycle where busy is low and was high on the previous cycle. Channel k (1 to 8) sits at conv_data bits [(k-1)*18 +: 18]. A change of conv_data with no busy falling edge leaves the shifted data unchanged.
- R2: After reset, and on the cycle after cs_n is seen high, oe_a, oe_b and first_oe are all 0.
- R3: On the cycle after cs_n is seen low in IDLE, the enables turn on and the MSB (bit 17) of the first channel of each active lane is presented. That is channel 1 on lane A and channel 5 on lane B in dual mode, and channel 1 on lane B in single mode.
- R4: Each serial-clock rising edge that follows a falling edge within the frame presents the next lower bit. After bit 0 of a result, the lane moves to bit 17 of the next channel.
- R5: With dual_mode = 1, lane A sends channels 1 to 4 and lane B sends channels 5 to 8 at the same time, with oe_a and oe_b both 1.
- R6: With dual_mode = 0, lane B sends channels 1 to 8 in order over 144 bits, and oe_a and dout_a stay 0.
- R7: In dual mode, first_ch goes to 1 together with the enables and returns to 0 after the 18th serial-clock falling edge of the frame. first_oe is 1 for the whole frame.
- R8: In single mode, first_ch stays 0 for the whole frame, including while channel 1 is on lane B.
- R9: Rising edges beyond the bits the mode needs (72 in dual, 144 in single) drive zeros on the data lanes, and the enables stay on.
- R10: A chip-select rising edge mid-frame clears the bit and channel position, so the next frame starts again at the MSB of the first channel.
- R11: The lane mode is sampled when the frame starts. A change of dual_mode during a frame has no effect until the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| busy | input | 1 | Converter busy; its falling edge loads results |
| conv_data | input | 144 | Eight 18-bit results, channel 1 in the lowest bits |
| dual_mode | input | 1 | 1 = two lanes, 0 = all channels on lane B |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock from the host |
| dout_a | output | 1 | Lane A serial data |
| oe_a | output | 1 | Lane A output enable |
| dout_b | output | 1 | Lane B serial data |
| oe_b | output | 1 | Lane B output enable |
| first_ch | output | 1 | First-channel flag |
| first_oe | output | 1 | First-channel flag output enable |

## Verification
The in-line assertions check, on every cycle, the properties that hold cycle by cycle. These are: enables released after a high chip select, the result registers loading only on a busy fall, the bit counter staying in range and stepping by one, the restart to position zero, the flag dropping on the 18th fall, and lane A plus the flag staying quiet in single mode. Only the bench's frames can show that the right bit of the right channel reaches each lane in each mode. The frames also cover zero padding after the last bit, a restart after an aborted frame, and the mode being held when dual_mode changes mid-frame. The bench checks these against results it captures itself.

// File: rtl/ser_out_pkg.sv
package ser_out_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DRAIN = 2'd2
    } frame_state_e;

endpackage

// File: rtl/sig_edge.sv
module sig_edge #(
    parameter bit RISING = 1'b1,
    parameter bit INIT   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic edge_o
);

    logic prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= INIT;
        end else begin
            prev_q <= sig_i;
        end
    end

    generate
        if (RISING) begin : g_rise
            assign edge_o = sig_i & ~prev_q;
        end else begin : g_fall
            assign edge_o = ~sig_i & prev_q;
        end
    endgenerate

endmodule

// File: rtl/result_bank.sv
module result_bank #(
    parameter int unsigned CH_COUNT = 8,
    parameter int unsigned RES_W    = 18
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      load_i,
    input  logic [CH_COUNT*RES_W-1:0] data_i,
    output logic [CH_COUNT*RES_W-1:0] data_o
);

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_chan
        logic [RES_W-1:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (load_i) begin
                word_q <= data_i[g*RES_W +: RES_W];
            end
        end

        assign data_o[g*RES_W +: RES_W] = word_q;
    end

    // R1: results change only on the busy falling edge
    p_load_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (data_o == $past(data_i)));

    p_hold_between_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(data_o));

endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import ser_out_pkg::*;
#(
    parameter int unsigned CH_COUNT = 8,
    parameter int unsigned RES_W    = 18,
    localparam int unsigned BIT_W   = $clog2(RES_W),
    localparam int unsigned CH_W    = $clog2(CH_COUNT),
    localparam int unsigned FALL_W  = $clog2(RES_W + 1),
    localparam int unsigned HALF    = CH_COUNT / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sclk_rise_i,
    input  logic             sclk_fall_i,
    input  logic             dual_mode_i,
    output frame_state_e     state_o,
    output logic [BIT_W-1:0] bit_o,
    output logic [CH_W-1:0]  ch_o,
    output logic             dual_o,
    output logic             first_o,
    output logic             active_o,
    output logic             shifting_o
);

    frame_state_e      state_q, state_d;
    logic [BIT_W-1:0]  bit_q;
    logic [CH_W-1:0]   ch_q;
    logic [FALL_W-1:0] fall_q;
    logic              dual_q;
    logic              first_q;
    logic              armed_q;
    logic              start;
    logic              advance;
    logic              word_end;
    logic              last_ch;
    logic [CH_W-1:0]   last_idx;

    assign start    = (state_q == ST_IDLE) && !cs_n_i;
    assign advance  = sclk_rise_i && armed_q;
    assign last_idx = dual_q ? CH_W'(HALF - 1) : CH_W'(CH_COUNT - 1);
    assign word_end = (bit_q == BIT_W'(RES_W - 1));
    assign last_ch  = (ch_q == last_idx);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!cs_n_i) state_d = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (cs_n_i)                          state_d = ST_IDLE;
                else if (advance && word_end && last_ch) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (cs_n_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // position counters and flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= '0;
            ch_q    <= '0;
            fall_q  <= '0;
            dual_q  <= 1'b0;
            first_q <= 1'b0;
            armed_q <= 1'b0;
        end else if (cs_n_i) begin
            bit_q   <= '0;
            ch_q    <= '0;
            fall_q  <= '0;
            first_q <= 1'b0;
            armed_q <= 1'b0;
        end else if (start) begin
            bit_q   <= '0;
            ch_q    <= '0;
            fall_q  <= '0;
            dual_q  <= dual_mode_i;
            first_q <= dual_mode_i;
            armed_q <= 1'b0;
        end else begin
            if (sclk_fall_i) begin
                armed_q <= 1'b1;
            end else if (sclk_rise_i) begin
                armed_q <= 1'b0;
            end
            if (sclk_fall_i && fall_q < FALL_W'(RES_W)) begin
                fall_q <= fall_q + 1'b1;
                if (fall_q == FALL_W'(RES_W - 1)) begin
                    first_q <= 1'b0;
                end
            end
            if (state_q == ST_SHIFT && advance) begin
                if (word_end) begin
                    bit_q <= '0;
                    if (!last_ch) ch_q <= ch_q + 1'b1;
                end else begin
                    bit_q <= bit_q + 1'b1;
                end
            end
        end
    end

    // outputs
    always_comb begin
        active_o   = 1'b0;
        shifting_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  begin active_o = 1'b0; shifting_o = 1'b0; end
            ST_SHIFT: begin active_o = 1'b1; shifting_o = 1'b1; end
            ST_DRAIN: begin active_o = 1'b1; shifting_o = 1'b0; end
            default:  begin active_o = 1'b0; shifting_o = 1'b0; end
        endcase
    end

    assign state_o = state_q;
    assign bit_o   = bit_q;
    assign ch_o    = ch_q;
    assign dual_o  = dual_q;
    assign first_o = first_q;

    // R4: bit position never leaves the word
    p_bit_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_q < BIT_W'(RES_W));

    // R4: a mid-word advance steps the position by one
    p_bit_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHIFT && !cs_n_i && advance && !word_end)
        |=> (bit_q == BIT_W'($past(bit_q) + 1'b1)));

    // R10: a new frame begins at the first bit of the first channel
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (bit_q == '0 && ch_q == '0 && state_q == ST_SHIFT));

    // R7: the flag falls on the 18th serial-clock falling edge
    p_first_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_i && state_q != ST_IDLE && sclk_fall_i && fall_q == FALL_W'(RES_W - 1))
        |=> !first_q);

endmodule

// File: rtl/lane_mux.sv
module lane_mux #(
    parameter int unsigned CH_COUNT = 8,
    parameter int unsigned RES_W    = 18,
    localparam int unsigned BIT_W   = $clog2(RES_W),
    localparam int unsigned CH_W    = $clog2(CH_COUNT),
    localparam int unsigned HALF    = CH_COUNT / 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [CH_COUNT*RES_W-1:0] bank_i,
    input  logic [BIT_W-1:0]          bit_i,
    input  logic [CH_W-1:0]           ch_i,
    input  logic                      dual_i,
    input  logic                      active_i,
    input  logic                      shifting_i,
    output logic                      dout_a_o,
    output logic                      oe_a_o,
    output logic                      dout_b_o,
    output logic                      oe_b_o
);

    logic [RES_W-1:0] word [CH_COUNT];
    logic [BIT_W-1:0] pos;
    logic [CH_W-1:0]  ch_b;

    for (genvar g = 0; g < CH_COUNT; g++) begin : g_unpack
        assign word[g] = bank_i[g*RES_W +: RES_W];
    end

    assign pos  = BIT_W'(RES_W - 1) - bit_i;
    assign ch_b = dual_i ? (ch_i + CH_W'(HALF)) : ch_i;

    always_comb begin
        oe_a_o   = active_i && dual_i;
        oe_b_o   = active_i;
        dout_a_o = 1'b0;
        dout_b_o = 1'b0;
        if (shifting_i) begin
            dout_b_o = word[ch_b][pos];
            if (dual_i) dout_a_o = word[ch_i][pos];
        end
    end

    // R9: past the last bit the lanes stay enabled and quiet
    p_drain_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !shifting_i) |-> (!dout_a_o && !dout_b_o && oe_b_o));

endmodule

// File: rtl/ser_out_shifter.sv
module ser_out_shifter
    import ser_out_pkg::*;
#(
    parameter int unsigned CH_COUNT = 8,
    parameter int unsigned RES_W    = 18,
    localparam int unsigned BIT_W   = $clog2(RES_W),
    localparam int unsigned CH_W    = $clog2(CH_COUNT),
    localparam int unsigned DATA_W  = CH_COUNT * RES_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              busy,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              dual_mode,
    input  logic              cs_n,
    input  logic              sclk,
    output logic              dout_a,
    output logic              oe_a,
    output logic              dout_b,
    output logic              oe_b,
    output logic              first_ch,
    output logic              first_oe
);

    logic              busy_fall;
    logic              sclk_rise;
    logic              sclk_fall;
    logic [DATA_W-1:0] bank;
    frame_state_e      state;
    logic [BIT_W-1:0]  bit_pos;
    logic [CH_W-1:0]   ch_pos;
    logic              dual_lat;
    logic              first_flag;
    logic              active;
    logic              shifting;

    sig_edge #(.RISING(1'b0), .INIT(1'b0)) i_busy_edge (
        .clk(clk), .rst_n(rst_n), .sig_i(busy), .edge_o(busy_fall)
    );

    sig_edge #(.RISING(1'b1), .INIT(1'b1)) i_sclk_rise (
        .clk(clk), .rst_n(rst_n), .sig_i(sclk), .edge_o(sclk_rise)
    );

    sig_edge #(.RISING(1'b0), .INIT(1'b1)) i_sclk_fall (
        .clk(clk), .rst_n(rst_n), .sig_i(sclk), .edge_o(sclk_fall)
    );

    result_bank #(.CH_COUNT(CH_COUNT), .RES_W(RES_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .load_i(busy_fall),
        .data_i(conv_data), .data_o(bank)
    );

    frame_seq #(.CH_COUNT(CH_COUNT), .RES_W(RES_W)) i_seq (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n),
        .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
        .dual_mode_i(dual_mode), .state_o(state),
        .bit_o(bit_pos), .ch_o(ch_pos), .dual_o(dual_lat),
        .first_o(first_flag), .active_o(active), .shifting_o(shifting)
    );

    lane_mux #(.CH_COUNT(CH_COUNT), .RES_W(RES_W)) i_mux (
        .clk(clk), .rst_n(rst_n), .bank_i(bank),
        .bit_i(bit_pos), .ch_i(ch_pos), .dual_i(dual_lat),
        .active_i(active), .shifting_i(shifting),
        .dout_a_o(dout_a), .oe_a_o(oe_a), .dout_b_o(dout_b), .oe_b_o(oe_b)
    );

    assign first_ch = first_flag;
    assign first_oe = active;

    // R2: deselect releases every enable
    p_hiz_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!oe_a && !oe_b && !first_oe && state == ST_IDLE));

    // R8: a single-lane frame never raises the flag
    p_single_no_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_b && !oe_a) |-> !first_ch);

    // R6: lane A is silent in single-lane mode
    p_single_lane_a_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_b && !oe_a) |-> !dout_a);

endmodule

// File: tb/test_ser_out_shifter.sv
`timescale 1ns/1ps
module test_ser_out_shifter;

    localparam int CH = 8;
    localparam int W  = 18;

    logic          clk = 1'b0;
    logic          rst_n, busy, dual_mode, cs_n, sclk;
    logic [CH*W-1:0] conv_data;
    logic          dout_a, oe_a, dout_b, oe_b, first_ch, first_oe;

    int n_cmp = 0;
    int n_bad = 0;
    logic [W-1:0] ref_q [CH];

    always #2.5 clk = ~clk;

    ser_out_shifter i_ser_out_shifter (
        .clk(clk), .rst_n(rst_n), .busy(busy), .conv_data(conv_data),
        .dual_mode(dual_mode), .cs_n(cs_n), .sclk(sclk),
        .dout_a(dout_a), .oe_a(oe_a), .dout_b(dout_b), .oe_b(oe_b),
        .first_ch(first_ch), .first_oe(first_oe)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_bit(input bit lane_b, input bit dual, input int n);
        int ch  = n / W;
        int pos = W - 1 - (n % W);
        int lim = dual ? CH / 2 : CH;
        if (ch >= lim) return 1'b0;
        if (!lane_b) return dual ? ref_q[ch][pos] : 1'b0;
        return dual ? ref_q[ch + CH / 2][pos] : ref_q[ch][pos];
    endfunction

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic check_lanes(input bit dual, input int n, input string tag);
        string t;
        int lim = dual ? CH / 2 : CH;
        if (tag != "")          t = tag;
        else if (n >= lim * W)  t = "R9";
        else if (dual)          t = "R4/R5";
        else                    t = "R4/R6";
        check(t, oe_a, dual);
        check(t, oe_b, 1'b1);
        check(t, dout_a, exp_bit(1'b0, dual, n));
        check(t, dout_b, exp_bit(1'b1, dual, n));
    endtask

    task automatic load_random();
        logic [W-1:0] nw [CH];
        @(negedge clk);
        for (int k = 0; k < CH; k++) begin
            nw[k] = W'($urandom);
            conv_data[k*W +: W] = nw[k];
        end
        busy = 1'b1;
        settle();
        @(negedge clk);
        busy = 1'b0;
        settle();
        for (int k = 0; k < CH; k++) ref_q[k] = nw[k];
    endtask

    task automatic run_frame(input bit dual, input int nclk, input int flip_at,
                             input string start_tag);
        int n = 0;
        int falls = 0;
        @(negedge clk);
        dual_mode = dual;
        cs_n = 1'b0;
        sclk = 1'b1;
        settle();
        check_lanes(dual, 0, start_tag);
        check(dual ? "R7" : "R8", first_ch, dual);
        check("R7", first_oe, 1'b1);
        for (int i = 0; i < nclk; i++) begin
            @(negedge clk);
            sclk = 1'b0;
            if (i == flip_at) dual_mode = ~dual_mode;
            settle();
            falls++;
            check(dual ? "R7" : "R8", first_ch, dual && (falls < W));
            @(negedge clk);
            sclk = 1'b1;
            settle();
            n++;
            check_lanes(dual, n, (flip_at >= 0 && i >= flip_at) ? "R11" : "");
        end
        @(negedge clk);
        cs_n = 1'b1;
        settle();
        check("R2", oe_a, 1'b0);
        check("R2", oe_b, 1'b0);
        check("R2", first_oe, 1'b0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20611));
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; busy = 1'b0;
        dual_mode = 1'b1; conv_data = '0;
        for (int k = 0; k < CH; k++) ref_q[k] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        settle();
        check("R2", oe_a, 1'b0);
        check("R2", oe_b, 1'b0);
        check("R2", first_oe, 1'b0);

        load_random();
        run_frame(1'b1, 72, -1, "R3");
        run_frame(1'b0, 144, -1, "R3");
        run_frame(1'b1, 80, -1, "R3");
        run_frame(1'b0, 150, -1, "R3");

        // R10: aborted frame, then a fresh one
        run_frame(1'b1, 25, -1, "R3");
        run_frame(1'b1, 40, -1, "R10");
        run_frame(1'b0, 30, -1, "R3");
        run_frame(1'b0, 20, -1, "R10");

        // R11: mode input flips mid-frame
        run_frame(1'b1, 50, 10, "R3");
        run_frame(1'b0, 60, 5, "R3");

        // R1: new input data with no busy fall is not taken
        @(negedge clk);
        for (int k = 0; k < CH; k++) conv_data[k*W +: W] = ~ref_q[k];
        settle();
        run_frame(1'b1, 36, -1, "R1");
        load_random();
        run_frame(1'b1, 20, -1, "R1");

        for (int r = 0; r < 12; r++) begin
            int nclk;
            int flip;
            bit dual;
            load_random();
            dual = 1'($urandom_range(1, 0));
            nclk = int'($urandom_range(160, 0));
            flip = ($urandom_range(3, 0) == 0) ? int'($urandom_range(40, 0)) : -1;
            run_frame(dual, nclk, flip, "R3");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule